// File: doc/BRIEF.md
# Sensor Electronic Shutter Sequencer

This block drives the substrate discharge (electronic shutter) pulse of an image-sensor timing generator. It also decides whether the readout line of each field is allowed to carry the readout transfer. It runs on the master pixel clock and follows two active-low sync inputs. A falling edge on the vertical sync starts a field. A falling edge on the horizontal sync starts a line.

A 2-bit mode selects the behaviour. Mode 00 stops the shutter. Mode 01 enables high-speed and low-speed exposure. Modes 10 and 11 suppress readout. In mode 01, three values set the exposure:

- An 8-bit field count: 0 means high-speed, N means an exposure of N+1 fields.
- A 10-bit line count: count+1 discharge pulses, one per line.
- An 8-bit position: which field of a long exposure carries the burst.

While a long exposure is in progress, the block raises a hold flag and ignores register writes. A write that is accepted is applied at the first field start after the current exposure ends.

Top module: `shut_seq`

## Requirements
- R1: With mode 00 in effect, no discharge pulse is emitted and the readout line is enabled in every field.
- R2: With mode 01 and field count 0 (high-speed), every field carries min(line count + 1, RD_LINE) pulses and enables readout, whatever the position value.
- R3: Discharge pulses fall only on the lines just before line RD_LINE, one pulse per line. Each pulse is PULSE_LEN clocks long. It rises at the clock count PULSE_OFS after the horizontal sync falling edge, counting from 0 at the edge where that edge is sampled. The sequencer output register adds one clock to that.
- R4: With mode 01 and field count N > 0, an exposure lasts N+1 fields indexed 0..N. Pulses appear only in the field whose index equals the position value. Readout is enabled only in field N.
- R5: A position value greater than the field count yields an exposure with no pulses at all.
- R6: `load_hold` is high during fields 0..N-1 of a low-speed exposure and low otherwise. A register write made while it is high is discarded.
- R7: Modes 10 and 11 emit no pulse and no readout, and they ignore the shutter values.
- R8: An accepted write changes nothing in the current field. It is applied at the next vertical sync falling edge that ends the running exposure.
- R9: Reset clears all shutter values to zero (mode 00). No pulse or readout appears before the first vertical sync falling edge.
- R10: A vertical sync falling edge restarts line numbering at 0. Each horizontal sync falling edge advances the line number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | master pixel clock |
| rst_n | input | 1 | active-low asynchronous reset |
| vsync_n | input | 1 | vertical sync, falling edge starts a field |
| hsync_n | input | 1 | horizontal sync, falling edge starts a line |
| cfg_wr | input | 1 | register write strobe |
| cfg_mode | input | 2 | shutter mode (00 stop, 01 expose, 10/11 suppress readout) |
| cfg_vper | input | 8 | field count of the exposure |
| cfg_hlines | input | 10 | pulse count minus one |
| cfg_pos | input | 8 | index of the field carrying the burst |
| sub_pulse | output | 1 | substrate discharge pulse |
| readout_en | output | 1 | high over the readout line when readout is allowed |
| load_hold | output | 1 | register writes are currently discarded |

## Verification
The high-speed check sweeps the line count across and beyond the field length. This separates the burst-length arithmetic from clamping at the readout line. A low-speed sweep covers every field count from 1 to 3 with every position from 0 to one past the count. It shows whether the burst field, the readout field and the hold window each follow the field index, and whether an out-of-range position suppresses everything. Writes are made in the middle of a field, both while the hold flag is high and while it is low. These separate a discarded write from a deferred one. A truncated field followed by a full one shows that the vertical edge restarts line numbering.

// File: rtl/shut_pkg.sv
package shut_pkg;
    localparam int VPER_W = 8;
    localparam int HL_W   = 10;
    localparam int POS_W  = 8;

    typedef enum logic [1:0] {
        MODE_STOP   = 2'b00,
        MODE_EXPOSE = 2'b01,
        MODE_NORD   = 2'b10,
        MODE_NORD_B = 2'b11
    } shut_mode_e;

    typedef struct packed {
        shut_mode_e          mode;
        logic [VPER_W-1:0]   vper;
        logic [HL_W-1:0]     hlines;
        logic [POS_W-1:0]    pos;
    } shut_cfg_t;

    localparam int CFG_W = $bits(shut_cfg_t);
endpackage

// File: rtl/sync_fall_det.sv
module sync_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sync_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end

    assign fall = prev_q & ~sync_n;
endmodule

// File: rtl/line_timer.sv
module line_timer #(
    parameter int LINE_W = 11,
    parameter int PIX_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vs_fall,
    input  logic              hs_fall,
    output logic [LINE_W-1:0] line,
    output logic [PIX_W-1:0]  pix,
    output logic              valid
);
    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [PIX_W-1:0]  pix;
        logic              valid;
    } lt_state_t;

    lt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (vs_fall) begin
            st_d.line  = '0;
            st_d.pix   = '0;
            st_d.valid = 1'b1;
        end else if (hs_fall) begin
            st_d.pix = '0;
            if (st_q.line != {LINE_W{1'b1}}) st_d.line = st_q.line + 1'b1;
        end else if (st_q.pix != {PIX_W{1'b1}}) begin
            st_d.pix = st_q.pix + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line  = st_q.line;
    assign pix   = st_q.pix;
    assign valid = st_q.valid;
endmodule

// File: rtl/field_seq.sv
module field_seq
    import shut_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vs_fall,
    input  shut_cfg_t         pend,
    output shut_cfg_t         act,
    output logic [VPER_W-1:0] fidx,
    output logic              pulse_en,
    output logic              ro_en,
    output logic              hold
);
    typedef struct packed {
        shut_cfg_t         act;
        logic [VPER_W-1:0] fidx;
    } fs_state_t;

    fs_state_t st_d, st_q;
    logic exposing, last_field;

    always_comb begin
        exposing   = (st_q.act.mode == MODE_EXPOSE);
        last_field = (st_q.fidx == st_q.act.vper);
        st_d = st_q;
        if (vs_fall) begin
            if (!exposing || last_field) begin
                st_d.act  = pend;
                st_d.fidx = '0;
            end else begin
                st_d.fidx = st_q.fidx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act      = st_q.act;
    assign fidx     = st_q.fidx;
    assign pulse_en = exposing &&
                      ((st_q.act.vper == '0) || (st_q.fidx == st_q.act.pos));
    assign ro_en    = (st_q.act.mode == MODE_STOP) || (exposing && last_field);
    assign hold     = exposing && (st_q.act.vper != '0) && !last_field;
endmodule

// File: rtl/pulse_gen.sv
module pulse_gen #(
    parameter int LINE_W    = 11,
    parameter int PIX_W     = 12,
    parameter int HL_W      = 10,
    parameter int RD_LINE   = 1200,
    parameter int PULSE_OFS = 56,
    parameter int PULSE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line,
    input  logic [PIX_W-1:0]  pix,
    input  logic              valid,
    input  logic              pulse_en,
    input  logic              ro_en,
    input  logic [HL_W-1:0]   hlines,
    output logic              sub,
    output logic              ro
);
    localparam int WIN_END = PULSE_OFS + PULSE_LEN;

    typedef struct packed {
        logic sub;
        logic ro;
    } pg_state_t;

    pg_state_t st_d, st_q;
    logic in_burst, in_win, at_rd;

    always_comb begin
        at_rd    = (32'(line) == RD_LINE);
        in_burst = (32'(line) < RD_LINE) &&
                   (32'(line) + 32'(hlines) + 32'd1 >= RD_LINE);
        in_win   = (32'(pix) >= PULSE_OFS) && (32'(pix) < WIN_END);
        st_d.sub = valid && pulse_en && in_burst && in_win;
        st_d.ro  = valid && ro_en && at_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sub = st_q.sub;
    assign ro  = st_q.ro;
endmodule

// File: rtl/shut_seq.sv
module shut_seq
    import shut_pkg::*;
#(
    parameter int LINE_W    = 11,
    parameter int PIX_W     = 12,
    parameter int RD_LINE   = 1200,
    parameter int PULSE_OFS = 56,
    parameter int PULSE_LEN = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vsync_n,
    input  logic       hsync_n,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_mode,
    input  logic [7:0] cfg_vper,
    input  logic [9:0] cfg_hlines,
    input  logic [7:0] cfg_pos,
    output logic       sub_pulse,
    output logic       readout_en,
    output logic       load_hold
);
    localparam int NSYNC = 2;

    logic [NSYNC-1:0] sync_in, sync_fall;
    shut_cfg_t pend_d, pend_q, act_cfg;
    logic [VPER_W-1:0] fidx;
    logic [LINE_W-1:0] line;
    logic [PIX_W-1:0]  pix;
    logic valid, pulse_en, ro_en;

    assign sync_in = {hsync_n, vsync_n};

    generate
        for (genvar gi = 0; gi < NSYNC; gi++) begin : g_sync
            sync_fall_det u_det (
                .clk(clk), .rst_n(rst_n), .sync_n(sync_in[gi]), .fall(sync_fall[gi])
            );
        end
    endgenerate

    always_comb begin
        pend_d = pend_q;
        if (cfg_wr && !load_hold) begin
            pend_d.mode   = shut_mode_e'(cfg_mode);
            pend_d.vper   = cfg_vper;
            pend_d.hlines = cfg_hlines;
            pend_d.pos    = cfg_pos;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    line_timer #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_lt (
        .clk(clk), .rst_n(rst_n), .vs_fall(sync_fall[0]), .hs_fall(sync_fall[1]),
        .line(line), .pix(pix), .valid(valid)
    );

    field_seq u_fs (
        .clk(clk), .rst_n(rst_n), .vs_fall(sync_fall[0]), .pend(pend_q),
        .act(act_cfg), .fidx(fidx), .pulse_en(pulse_en), .ro_en(ro_en),
        .hold(load_hold)
    );

    pulse_gen #(
        .LINE_W(LINE_W), .PIX_W(PIX_W), .HL_W(HL_W), .RD_LINE(RD_LINE),
        .PULSE_OFS(PULSE_OFS), .PULSE_LEN(PULSE_LEN)
    ) u_pg (
        .clk(clk), .rst_n(rst_n), .line(line), .pix(pix), .valid(valid),
        .pulse_en(pulse_en), .ro_en(ro_en), .hlines(act_cfg.hlines),
        .sub(sub_pulse), .ro(readout_en)
    );
endmodule

// File: rtl/shut_seq_chk.sv
module shut_seq_chk #(
    parameter int LINE_W  = 11,
    parameter int CFG_W   = 28,
    parameter int RD_LINE = 1200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sub_pulse,
    input logic              readout_en,
    input logic              load_hold,
    input logic              cfg_wr,
    input logic [1:0]        act_mode,
    input logic [7:0]        act_vper,
    input logic [7:0]        fidx,
    input logic [CFG_W-1:0]  pend_bits,
    input logic [LINE_W-1:0] line
);
    // R1
    stop_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode == 2'b00 && $past(act_mode) == 2'b00) |-> !sub_pulse);

    // R7
    nord_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mode[1] && $past(act_mode[1])) |-> (!sub_pulse && !readout_en));

    // R6
    hold_drops_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_hold && cfg_wr) |=> $stable(pend_bits));

    // R6
    hold_lowspeed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_hold |-> (act_mode == 2'b01 && act_vper != 8'd0));

    // R4
    fidx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fidx <= act_vper);

    // R3
    burst_before_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sub_pulse |-> (32'($past(line)) < RD_LINE));
endmodule

bind shut_seq shut_seq_chk #(
    .LINE_W(LINE_W), .CFG_W(shut_pkg::CFG_W), .RD_LINE(RD_LINE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sub_pulse(sub_pulse), .readout_en(readout_en),
    .load_hold(load_hold), .cfg_wr(cfg_wr), .act_mode(act_cfg.mode),
    .act_vper(act_cfg.vper), .fidx(fidx), .pend_bits(pend_q), .line(line)
);

// File: tb/tb_shut_seq.sv
module tb_shut_seq;
    localparam int RD    = 11;
    localparam int NL    = 12;
    localparam int LCLK  = 16;
    localparam int OFS   = 4;
    localparam int LEN   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vsync_n = 1'b1, hsync_n = 1'b1, cfg_wr = 1'b0;
    logic [1:0] cfg_mode = '0;
    logic [7:0] cfg_vper = '0, cfg_pos = '0;
    logic [9:0] cfg_hlines = '0;
    logic sub_pulse, readout_en, load_hold;

    int errors = 0, checks = 0;
    int pcnt, hicnt, rocnt, first_line, first_cyc, cyc, cur_line;
    bit sub_prev = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    shut_seq #(.RD_LINE(RD), .PULSE_OFS(OFS), .PULSE_LEN(LEN)) dut (
        .clk(clk), .rst_n(rst_n), .vsync_n(vsync_n), .hsync_n(hsync_n),
        .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_vper(cfg_vper),
        .cfg_hlines(cfg_hlines), .cfg_pos(cfg_pos),
        .sub_pulse(sub_pulse), .readout_en(readout_en), .load_hold(load_hold)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (sub_pulse) hicnt++;
        if (sub_pulse && !sub_prev) begin
            if (pcnt == 0) begin
                first_line = cur_line;
                first_cyc  = cyc;
            end
            pcnt++;
        end
        if (readout_en) rocnt++;
        sub_prev = sub_pulse;
    endtask

    task automatic set_cfg(int m, int v, int h, int p);
        cfg_mode = 2'(m); cfg_vper = 8'(v); cfg_hlines = 10'(h); cfg_pos = 8'(p);
    endtask

    task automatic write_cfg(int m, int v, int h, int p);
        step();
        set_cfg(m, v, h, p);
        cfg_wr = 1'b1;
        step();
        cfg_wr = 1'b0;
    endtask

    // One field of nlines lines; optional write in line 5.
    task automatic run_field(string req, bit use_vs, int nlines, int exp_p,
                             int exp_ro, int exp_hold, int exp_first,
                             bit wr_mid, int wm, int wv, int wh, int wp);
        int hold_s = 0;
        for (int ln = 0; ln < nlines; ln++) begin
            step();
            hsync_n = 1'b0;
            if (ln == 0 && use_vs) vsync_n = 1'b0;
            cur_line = ln;
            cyc = 0;
            step();
            hsync_n = 1'b1;
            vsync_n = 1'b1;
            if (ln == 0) begin
                pcnt = 0; hicnt = 0; rocnt = 0; first_line = -1; first_cyc = -1;
            end
            for (int k = 2; k < LCLK; k++) begin
                step();
                if (ln == 2 && k == 2) hold_s = int'(load_hold);
                if (ln == 5 && k == 6 && wr_mid) begin
                    set_cfg(wm, wv, wh, wp);
                    cfg_wr = 1'b1;
                end else begin
                    cfg_wr = 1'b0;
                end
            end
        end
        check({req, " pulse count"}, pcnt, exp_p);
        check({req, " readout"}, int'(rocnt > 0), exp_ro);
        check({req, " hold"}, hold_s, exp_hold);
        check({req, " pulse width (R3)"}, hicnt, exp_p * LEN);
        if (exp_p > 0) begin
            check({req, " first burst line (R3)"}, first_line, exp_first);
            check({req, " pulse offset (R3)"}, first_cyc, OFS + 2);
        end
    endtask

    function automatic int nburst(int h);
        return (h + 1 < RD) ? h + 1 : RD;
    endfunction

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                if (!done) begin
                    errors++; checks++;
                    $display("FAIL watchdog expired");
                    $display("Result: errors=%0d of %0d checks", errors, checks);
                    $finish;
                end
            end
        join_none

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R9 reset sub", int'(sub_pulse), 0);
        check("R9 reset hold", int'(load_hold), 0);

        // R9: no output before first vertical sync
        run_field("R9 pre-vsync", 1'b0, NL, 0, 0, 0, -1, 1'b0, 0, 0, 0, 0);
        // R1: reset values act as stop mode
        run_field("R1 stop", 1'b1, NL, 0, 1, 0, -1, 1'b0, 0, 0, 0, 0);

        // R2: high-speed sweep over line count, position ignored
        for (int h = 0; h <= 12; h++) begin
            write_cfg(1, 0, h, 5);
            run_field("R2 high-speed", 1'b1, NL, nburst(h), 1, 0, RD - nburst(h),
                      1'b0, 0, 0, 0, 0);
        end

        // R8: mid-field write deferred to the next field
        write_cfg(1, 0, 1, 0);
        run_field("R8 before", 1'b1, NL, 2, 1, 0, RD - 2, 1'b1, 1, 0, 4, 0);
        run_field("R8 after", 1'b1, NL, 5, 1, 0, RD - 5, 1'b0, 0, 0, 0, 0);

        // R10: truncated field, then vsync restarts line numbering
        write_cfg(1, 0, 2, 0);
        run_field("R10 short", 1'b1, 6, 0, 0, 0, -1, 1'b0, 0, 0, 0, 0);
        run_field("R10 full", 1'b1, NL, 3, 1, 0, RD - 3, 1'b0, 0, 0, 0, 0);

        // R4 / R5: low-speed sweep over field count and position
        for (int v = 1; v <= 3; v++) begin
            for (int p = 0; p <= v + 1; p++) begin
                write_cfg(1, v, 2, p);
                for (int f = 0; f <= v; f++) begin
                    run_field((p > v) ? "R5 pos beyond" : "R4 low-speed", 1'b1, NL,
                              (f == p) ? 3 : 0, (f == v) ? 1 : 0, (f != v) ? 1 : 0,
                              RD - 3, 1'b0, 0, 0, 0, 0);
                end
            end
        end

        // R6: write during hold is discarded; exposure repeats unchanged
        write_cfg(1, 1, 1, 0);
        for (int rep = 0; rep < 2; rep++) begin
            run_field("R6 hold field", 1'b1, NL, 2, 0, 1, RD - 2,
                      rep == 0, 0, 0, 0, 0);
            run_field("R6 last field", 1'b1, NL, 0, 1, 0, -1, 1'b0, 0, 0, 0, 0);
        end

        // R7: suppression modes ignore shutter values
        write_cfg(2, 0, 3, 0);
        run_field("R7 mode10", 1'b1, NL, 0, 0, 0, -1, 1'b0, 0, 0, 0, 0);
        write_cfg(3, 2, 3, 0);
        run_field("R7 mode11", 1'b1, NL, 0, 0, 0, -1, 1'b0, 0, 0, 0, 0);
        run_field("R7 mode11 again", 1'b1, NL, 0, 0, 0, -1, 1'b0, 0, 0, 0, 0);

        // R1: back to stop mode
        write_cfg(0, 0, 5, 0);
        run_field("R1 stop again", 1'b1, NL, 0, 1, 0, -1, 1'b0, 0, 0, 0, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule